// File: doc/BRIEF.md
# ROM Wait-State Generator

This block is the bus glue between a small 8-bit CPU, a fast RAM in the lower half of the address map and a slow ROM in the upper half. RAM accesses never stall. The RAM strobes come straight from the top address bit, the read/write line and the inverted PHI2 clock. Any access to the upper half makes a 4-bit counter, which normally rests at all ones, count through a stretch that holds RDY low. A static selector sets how long that stretch lasts.

The only output port is an 8-bit LED register, and it is loaded without the data bus. On each clock edge inside a wait stretch, the low address nibble is written into it as an addressable-latch command. Bits [2:0] pick the LED and bit 3 gives its new level. Software drives an LED by reading or writing a chosen upper-half address.

Top module: `rom_wait_gen`

## Requirements
- R1: A synchronous reset, sampled on a rising PHI2 edge, clears `led` to 0x00 and leaves `rdy` high, even if a wait stretch is running.
- R2: While `rdy` is high, a rising PHI2 edge with `addr_hi` low keeps `rdy` high after that edge.
- R3: While `rdy` is high, a rising PHI2 edge with `addr_hi` high drives `rdy` low for exactly N edges. The selector `wait_sel` gives N: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8 and 4 gives 15. `rdy` is high again after the N-th edge.
- R4: The `wait_sel` codes 5, 6 and 7 each give a 15-edge stretch.
- R5: `rom_en` is high exactly when `addr_hi` is high and `rw` is high (1 = read).
- R6: `ram_oe_n` equals `addr_hi`, and `ram_we_n` equals `rw`.
- R7: `ram_cs_n` is low while PHI2 is high and high while PHI2 is low.
- R8: On each rising PHI2 edge where `rdy` is low, `led[addr_lo[2:0]]` takes the value of `addr_lo[3]`. All other LED bits keep their values.
- R9: On a rising edge where `rdy` is high, `led` does not change, whatever the address nibble is.
- R10: If `addr_hi` stays high across two accesses, the edge that follows the single `rdy`-high cycle starts a new stretch of the same length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| phi2 | input | 1 | CPU PHI2 clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr_hi | input | 1 | Top CPU address bit (1 = ROM half) |
| rw | input | 1 | CPU read/write line (1 = read) |
| addr_lo | input | 4 | Low CPU address bits, used as the LED command |
| wait_sel | input | 3 | Static wait-length selector |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_cs_n | output | 1 | RAM chip select, active low |
| rom_en | output | 1 | ROM enable, active high |
| rdy | output | 1 | Ready to the CPU, low during wait states |
| led | output | 8 | LED register |

## Verification
Lower-half traffic runs with LED-writing nibbles on the address bus. This tells a correct decode apart from one that starts waits or latches LEDs outside a stretch. Single upper-half accesses are run under every selector code, both legal and illegal, and the stall length is counted. This separates the five lengths from each other and from a wrong fallback. Held-high back-to-back accesses and a reset in the middle of a stretch test the counter's restart and preset paths. A series of LED nibbles shows that only the addressed bit moves, and that it moves once per stalled edge.

// File: rtl/romws_pkg.sv
`timescale 1ns/1ps
package romws_pkg;
  localparam int CNT_W = 4;
  localparam int SEL_W = 3;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [SEL_W-1:0] {
    WS_ONE   = 3'd0,
    WS_TWO   = 3'd1,
    WS_FOUR  = 3'd2,
    WS_EIGHT = 3'd3,
    WS_MAX   = 3'd4
  } wait_code_e;

  // Last count value of a stretch (length minus one); unknown codes use the longest.
  function automatic cnt_t wait_last(input logic [SEL_W-1:0] code);
    case (code)
      WS_ONE:   return cnt_t'(0);
      WS_TWO:   return cnt_t'(1);
      WS_FOUR:  return cnt_t'(3);
      WS_EIGHT: return cnt_t'(7);
      default:  return cnt_t'(14);
    endcase
  endfunction
endpackage

// File: rtl/romws_sel_decode.sv
`timescale 1ns/1ps
module romws_sel_decode
  import romws_pkg::*;
(
  input  logic [SEL_W-1:0] wait_sel,
  output cnt_t             last_cnt
);
  always_comb last_cnt = wait_last(wait_sel);
endmodule

// File: rtl/romws_wait_counter.sv
`timescale 1ns/1ps
module romws_wait_counter
  import romws_pkg::*;
(
  input  logic phi2,
  input  logic rst,
  input  logic start,
  input  cnt_t last_cnt,
  output logic stall
);
  localparam cnt_t IDLE = '1;

  cnt_t cnt_q;

  // Resting value is all ones; a stretch counts up from zero to last_cnt.
  always_ff @(posedge phi2) begin
    if (rst) begin
      cnt_q <= IDLE;
    end else if (cnt_q == IDLE) begin
      if (start) cnt_q <= '0;
    end else if (cnt_q == last_cnt) begin
      cnt_q <= IDLE;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign stall = (cnt_q != IDLE);
endmodule

// File: rtl/romws_led_latch.sv
`timescale 1ns/1ps
module romws_led_latch #(
  parameter int LED_W = 8,
  localparam int IDX_W = (LED_W > 1) ? $clog2(LED_W) : 1
) (
  input  logic             phi2,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic             val,
  output logic [LED_W-1:0] led
);
  always_ff @(posedge phi2) begin
    if (rst) begin
      led <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < LED_W; i++) begin
        if (idx == IDX_W'(i)) led[i] <= val;
      end
    end
  end
endmodule

// File: rtl/romws_decode.sv
`timescale 1ns/1ps
module romws_decode (
  input  logic phi2,
  input  logic addr_hi,
  input  logic rw,
  output logic ram_oe_n,
  output logic ram_we_n,
  output logic ram_cs_n,
  output logic rom_en
);
  always_comb begin
    ram_oe_n = addr_hi;
    ram_we_n = rw;
    ram_cs_n = ~phi2;
    rom_en   = addr_hi & rw;
  end
endmodule

// File: rtl/rom_wait_gen.sv
`timescale 1ns/1ps
module rom_wait_gen
  import romws_pkg::*;
#(
  parameter int LED_W = 8,
  localparam int IDX_W = (LED_W > 1) ? $clog2(LED_W) : 1
) (
  input  logic             phi2,
  input  logic             rst,
  input  logic             addr_hi,
  input  logic             rw,
  input  logic [IDX_W:0]   addr_lo,
  input  logic [SEL_W-1:0] wait_sel,
  output logic             ram_oe_n,
  output logic             ram_we_n,
  output logic             ram_cs_n,
  output logic             rom_en,
  output logic             rdy,
  output logic [LED_W-1:0] led
);
  cnt_t last_cnt;
  logic stall;

  romws_sel_decode u_sel (
    .wait_sel (wait_sel),
    .last_cnt (last_cnt)
  );

  romws_wait_counter u_cnt (
    .phi2     (phi2),
    .rst      (rst),
    .start    (addr_hi),
    .last_cnt (last_cnt),
    .stall    (stall)
  );

  romws_led_latch #(.LED_W(LED_W)) u_led (
    .phi2  (phi2),
    .rst   (rst),
    .wr_en (stall),
    .idx   (addr_lo[IDX_W-1:0]),
    .val   (addr_lo[IDX_W]),
    .led   (led)
  );

  romws_decode u_dec (
    .phi2     (phi2),
    .addr_hi  (addr_hi),
    .rw       (rw),
    .ram_oe_n (ram_oe_n),
    .ram_we_n (ram_we_n),
    .ram_cs_n (ram_cs_n),
    .rom_en   (rom_en)
  );

  assign rdy = ~stall;
endmodule

// File: rtl/rom_wait_gen_chk.sv
`timescale 1ns/1ps
module rom_wait_gen_chk #(
  parameter int LED_W = 8
) (
  input logic             phi2,
  input logic             rst,
  input logic             addr_hi,
  input logic             rw,
  input logic             rom_en,
  input logic             ram_oe_n,
  input logic             rdy,
  input logic [LED_W-1:0] led
);
  logic [4:0] low_run;

  always_ff @(posedge phi2) begin
    if (rst)       low_run <= '0;
    else if (!rdy) low_run <= low_run + 1'b1;
    else           low_run <= '0;
  end

  AST_RESET_STATE: assert property (@(posedge phi2) rst |=> (rdy && led == '0)); // R1
  AST_IDLE_HOLD: assert property (@(posedge phi2) disable iff (rst) (rdy && !addr_hi) |=> rdy); // R2
  AST_ROM_STALL: assert property (@(posedge phi2) disable iff (rst) (rdy && addr_hi) |=> !rdy); // R3
  AST_MAX_STALL: assert property (@(posedge phi2) disable iff (rst) !rdy |-> (low_run < 5'd15)); // R4
  AST_ROM_WRITE_OFF: assert property (@(posedge phi2) disable iff (rst) !rw |-> !rom_en); // R5
  AST_RAM_ROM_EXCL: assert property (@(posedge phi2) disable iff (rst) rom_en |-> ram_oe_n); // R6
  AST_LED_QUIET: assert property (@(posedge phi2) disable iff (rst) rdy |=> $stable(led)); // R9
  AST_LED_ONE_BIT: assert property (@(posedge phi2) disable iff (rst) !rdy |=> ($countones(led ^ $past(led)) <= 1)); // R8
endmodule

bind rom_wait_gen rom_wait_gen_chk #(.LED_W(LED_W)) u_chk (
  .phi2     (phi2),
  .rst      (rst),
  .addr_hi  (addr_hi),
  .rw       (rw),
  .rom_en   (rom_en),
  .ram_oe_n (ram_oe_n),
  .rdy      (rdy),
  .led      (led)
);

// File: tb/rom_wait_gen_bench.sv
`timescale 1ns/1ps
module rom_wait_gen_bench;
  logic       phi2 = 1'b0;
  logic       rst = 1'b1;
  logic       addr_hi = 1'b0;
  logic       rw = 1'b1;
  logic [3:0] addr_lo = 4'h0;
  logic [2:0] wait_sel = 3'd0;
  logic       ram_oe_n, ram_we_n, ram_cs_n, rom_en, rdy;
  logic [7:0] led;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // behavioural reference state
  int         m_rem = 0;
  logic [7:0] m_led = 8'h00;
  string      phase = "R1";

  always #10 phi2 = ~phi2;

  rom_wait_gen u_rom_wait_gen (
    .phi2(phi2), .rst(rst), .addr_hi(addr_hi), .rw(rw), .addr_lo(addr_lo),
    .wait_sel(wait_sel), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n),
    .ram_cs_n(ram_cs_n), .rom_en(rom_en), .rdy(rdy), .led(led)
  );

  function automatic int stretch_len(input logic [2:0] s);
    int lens[5] = '{1, 2, 4, 8, 15};
    if (s < 3'd5) return lens[s];
    return 15;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cycle(input logic hi, input logic rwv, input logic [3:0] lo, input logic rs);
    @(negedge phi2);
    addr_hi = hi; rw = rwv; addr_lo = lo; rst = rs;
    #2;
    check("R5 rom_en", rom_en, hi & rwv);
    check("R6 ram_oe_n", ram_oe_n, hi);
    check("R6 ram_we_n", ram_we_n, rwv);
    check("R7 ram_cs_n low phase", ram_cs_n, 1);
    @(posedge phi2);
    if (rs) begin
      m_rem = 0; m_led = 8'h00;
    end else if (m_rem == 0) begin
      if (hi) m_rem = stretch_len(wait_sel);
    end else begin
      m_led[lo[2:0]] = lo[3];
      m_rem--;
    end
    #3;
    check({phase, " rdy"}, rdy, (m_rem == 0));
    check({phase, " led"}, led, m_led);
    check("R7 ram_cs_n high phase", ram_cs_n, 0);
  endtask

  // one upper-half access; returns number of stalled edges observed
  task automatic rom_access(input logic rwv, input logic [3:0] lo, output int low_cnt);
    low_cnt = 0;
    cycle(1'b1, rwv, lo, 1'b0);
    for (int k = 0; k < 40 && !rdy; k++) begin
      low_cnt++;
      cycle(1'b1, rwv, lo, 1'b0);
    end
  endtask

  initial begin
    int n;
    phase = "R1";
    for (int i = 0; i < 3; i++) cycle(1'b0, 1'b1, 4'hF, 1'b1);
    check("R1 rdy after reset", rdy, 1);
    check("R1 led after reset", led, 8'h00);

    phase = "R2";
    for (int i = 0; i < 8; i++) cycle(1'b0, i[0], 4'(8 + i), 1'b0);

    phase = "R9";
    for (int i = 0; i < 4; i++) cycle(1'b0, 1'b0, 4'(8 + 2 * i), 1'b0);
    check("R9 led untouched by lower half", led, 8'h00);

    phase = "R3";
    for (int s = 0; s < 5; s++) begin
      wait_sel = 3'(s);
      rom_access(1'b1, 4'(8 + s), n);
      check("R3 stretch length", n, stretch_len(3'(s)));
      cycle(1'b0, 1'b1, 4'h0, 1'b0);
    end

    phase = "R4";
    for (int s = 5; s < 8; s++) begin
      wait_sel = 3'(s);
      rom_access(1'b0, 4'(s - 5), n);
      check("R4 illegal code length", n, 15);
      cycle(1'b0, 1'b0, 4'h0, 1'b0);
    end

    phase = "R8";
    wait_sel = 3'd0;
    for (int i = 0; i < 8; i++) begin
      rom_access(1'b1, {1'b1, 3'(i)}, n);
      cycle(1'b0, 1'b1, 4'h7, 1'b0);
    end
    check("R8 all LEDs set", led, 8'hFF);
    rom_access(1'b0, 4'h2, n);
    rom_access(1'b1, 4'h5, n);
    cycle(1'b0, 1'b1, 4'h0, 1'b0);
    check("R8 two LEDs cleared", led, 8'hDB);

    phase = "R10";
    wait_sel = 3'd1;
    rom_access(1'b1, 4'h8, n);
    check("R10 first access length", n, 2);
    rom_access(1'b1, 4'h8, n);
    check("R10 back-to-back length", n, 2);
    cycle(1'b0, 1'b1, 4'h0, 1'b0);

    phase = "R1";
    wait_sel = 3'd4;
    cycle(1'b1, 1'b1, 4'hC, 1'b0);
    cycle(1'b1, 1'b1, 4'hC, 1'b0);
    cycle(1'b1, 1'b1, 4'hC, 1'b1);
    check("R1 reset mid-stretch rdy", rdy, 1);
    check("R1 reset mid-stretch led", led, 8'h00);
    cycle(1'b0, 1'b1, 4'h0, 1'b0);
    cycle(1'b0, 1'b1, 4'h0, 1'b0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule